// File: doc/BRIEF.md
# Parallel Video Line-Timing Parser

This block sits behind an 8-bit parallel digital video source running at pixel-clock rate (nominally 27 MHz). It watches the byte stream, which arrives with a byte-valid strobe, for four-byte timing codes. Each code is the prefix `FF 00 00` followed by a timing word. The block then splits every line into blanking and active video. Only active picture bytes are passed on, one per cycle with no loss, and each is marked with start-of-line and end-of-line flags and with the field and vertical-blanking bits taken from the code that opened it.

The block also measures each line. It latches the active-byte count, the blanking run length and the total length from one end-of-active code to the next. It checks that the blanking fill alternates `80`/`10`. Once two consecutive lines have the same total length, it reports whether that length is 625-line timing (1728 bytes), 525-line timing (1716 bytes) or neither. Malformed codes, wrong line lengths and broken fill raise sticky error flags that only reset clears.

A line is made of an end-of-active code, blanking, a start-of-active code and then exactly 1440 active bytes. Every output is registered, so a byte accepted at one clock edge shows its effect right after that edge.

Top module: `vline_parser`

## Requirements
- R1: A timing code is the byte run `FF 00 00 W` with all bytes accepted. W bit 4 selects end-of-active (1) or start-of-active (0). Bit 6 is the field, bit 5 the vertical-blank bit, and bit 7 must be 1. W bits 3..0 must equal {V^H, F^H, F^V, F^V^H}. A W failing either check sets the sticky `code_err` and causes no state change, so an invalid start code forwards no bytes.
- R2: After a valid start code, the next non-code bytes, up to 1440 of them, appear on `out_data` with `out_valid` high, one cycle after acceptance and in the same order. No other byte is forwarded.
- R3: `out_sol` is high only with the first forwarded byte of a line, and `out_eol` only with the 1440th.
- R4: `out_field` and `out_vblank` on forwarded bytes equal W bits 6 and 5 of the most recent valid start code.
- R5: Non-code bytes between an end code and the next start code must alternate `80`, `10`, beginning with `80`. Any other byte sets the sticky `blank_err`. Clean lines leave it at 0.
- R6: The sticky `len_err` is set by an end code that follows fewer than 1440 active bytes, by a start code during active video, by two end codes with no start code between them, and by a non-code byte arriving after 1440 active bytes. In the last case the byte is not forwarded and the block waits for the next valid code.
- R7: At each valid end code after the first since reset or resync, `meas_total` takes the number of bytes since the previous end code's timing word, counting the current timing word. `meas_active` takes the active count of the line just closed. At each start code that follows blanking, `meas_blank` takes the blanking run length, excluding the code's `FF 00 00` prefix.
- R8: At each measured end code, `std_mode` becomes `01` for 1728, `10` for 1716 or `11` for any other length, but only if the length equals the previous measured length. Otherwise it becomes `00`. An active overrun returns it to `00`.
- R9: Bytes presented while `in_valid` is low are ignored: they are not forwarded, and they are not counted or checked.
- R10: Reset (`rst` high at a clock edge) clears all outputs to 0 and `std_mode` to `00`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel byte clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input video byte |
| out_valid | output | 1 | Forwarded active byte strobe |
| out_data | output | 8 | Forwarded active byte |
| out_sol | output | 1 | First active byte of line |
| out_eol | output | 1 | Last active byte of line |
| out_field | output | 1 | Field bit of current line |
| out_vblank | output | 1 | Vertical-blank bit of current line |
| code_err | output | 1 | Sticky bad timing word |
| len_err | output | 1 | Sticky line length fault |
| blank_err | output | 1 | Sticky blanking fill fault |
| meas_active | output | CNT_W | Active bytes in last closed line |
| meas_total | output | CNT_W | Last measured total line length |
| meas_blank | output | CNT_W | Last measured blanking run |
| std_mode | output | 2 | Line standard classification |

## Verification
A wrong line state shows up on the very next byte. A parser stuck in blanking forwards nothing after a start code and raises `blank_err` on the first active byte. A parser stuck in active video forwards fill bytes. An off-by-one in the active counter moves `out_eol` or drops the 1440th byte within the same line, and it raises `len_err` at the following end code. Counter errors in the length measurement appear in `meas_total` and `std_mode` at the end code that closes the line. The directed scenarios therefore compare every forwarded byte and flag, and read the measurements right after the relevant code.

// File: rtl/vlp_pkg.sv
package vlp_pkg;

  typedef enum logic [1:0] {
    ST_UNSYNC = 2'd0,
    ST_BLANK  = 2'd1,
    ST_ACTIVE = 2'd2
  } line_st_t;

  localparam logic [7:0] PRE_HI  = 8'hFF;
  localparam logic [7:0] PRE_LO  = 8'h00;
  localparam logic [7:0] FILL_A  = 8'h80;
  localparam logic [7:0] FILL_B  = 8'h10;

  localparam logic [1:0] STD_NONE  = 2'b00;
  localparam logic [1:0] STD_625   = 2'b01;
  localparam logic [1:0] STD_525   = 2'b10;
  localparam logic [1:0] STD_OTHER = 2'b11;

  // timing word: [7]=1, [6]=F, [5]=V, [4]=H, [3:0]=protection
  function automatic logic word_ok(input logic [7:0] w);
    logic f, v, h;
    f = w[6];
    v = w[5];
    h = w[4];
    return w[7] && (w[3] == (v ^ h)) && (w[2] == (f ^ h)) &&
           (w[1] == (f ^ v)) && (w[0] == (f ^ v ^ h));
  endfunction

endpackage

// File: rtl/vlp_code_det.sv
module vlp_code_det
  import vlp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       code_byte,
  output logic       hit_good,
  output logic       hit_bad
);

  logic [1:0] phase;

  always_comb begin
    code_byte = in_valid &&
                (((phase == 2'd0) && (in_data == PRE_HI)) ||
                 ((phase == 2'd1) && (in_data == PRE_LO)) ||
                 ((phase == 2'd2) && (in_data == PRE_LO)) ||
                  (phase == 2'd3));
    hit_good = in_valid && (phase == 2'd3) &&  word_ok(in_data);
    hit_bad  = in_valid && (phase == 2'd3) && !word_ok(in_data);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 2'd0;
    end else if (in_valid) begin
      if (phase == 2'd3)                               phase <= 2'd0;
      else if (in_data == PRE_HI)                      phase <= 2'd1;
      else if ((phase == 2'd1) && (in_data == PRE_LO)) phase <= 2'd2;
      else if ((phase == 2'd2) && (in_data == PRE_LO)) phase <= 2'd3;
      else                                             phase <= 2'd0;
    end
  end

endmodule

// File: rtl/vlp_line_fsm.sv
module vlp_line_fsm
  import vlp_pkg::*;
#(
  parameter int ACT_LEN = 1440,
  parameter int CNT_W   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             code_byte,
  input  logic             hit_good,
  input  logic             hit_bad,
  output logic             o_valid,
  output logic [7:0]       o_data,
  output logic             o_sol,
  output logic             o_eol,
  output logic             o_field,
  output logic             o_vblank,
  output logic             code_err,
  output logic             len_err,
  output logic             blank_err,
  output logic [CNT_W-1:0] act_len,
  output logic             eav_evt,
  output logic             sav_after_blank,
  output logic             overrun
);

  localparam logic [CNT_W-1:0] ACT_MAX  = CNT_W'(ACT_LEN);
  localparam logic [CNT_W-1:0] ACT_LAST = CNT_W'(ACT_LEN - 1);

  line_st_t         st;
  logic [CNT_W-1:0] act_cnt;
  logic             fill_ph;
  logic             cur_f, cur_v;

  logic sav_evt, act_take, fill_chk, fill_bad, len_fault;

  always_comb begin
    eav_evt         = hit_good &&  in_data[4];
    sav_evt         = hit_good && !in_data[4];
    sav_after_blank = sav_evt && (st == ST_BLANK);
    act_take  = in_valid && !code_byte && (st == ST_ACTIVE) && (act_cnt < ACT_MAX);
    overrun   = in_valid && !code_byte && (st == ST_ACTIVE) && (act_cnt >= ACT_MAX);
    fill_chk  = in_valid && !code_byte && (st == ST_BLANK);
    fill_bad  = fill_chk && (in_data != (fill_ph ? FILL_B : FILL_A));
    len_fault = overrun ||
                (eav_evt && (st == ST_ACTIVE) && (act_cnt != ACT_MAX)) ||
                (eav_evt && (st == ST_BLANK)) ||
                (sav_evt && (st == ST_ACTIVE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_UNSYNC;
      act_cnt   <= '0;
      fill_ph   <= 1'b0;
      cur_f     <= 1'b0;
      cur_v     <= 1'b0;
      o_valid   <= 1'b0;
      o_data    <= '0;
      o_sol     <= 1'b0;
      o_eol     <= 1'b0;
      o_field   <= 1'b0;
      o_vblank  <= 1'b0;
      code_err  <= 1'b0;
      len_err   <= 1'b0;
      blank_err <= 1'b0;
      act_len   <= '0;
    end else begin
      o_valid <= act_take;
      o_sol   <= act_take && (act_cnt == '0);
      o_eol   <= act_take && (act_cnt == ACT_LAST);
      if (act_take) begin
        o_data   <= in_data;
        o_field  <= cur_f;
        o_vblank <= cur_v;
        act_cnt  <= act_cnt + 1'b1;
      end
      if (hit_bad)   code_err  <= 1'b1;
      if (len_fault) len_err   <= 1'b1;
      if (fill_bad)  blank_err <= 1'b1;
      if (fill_chk)  fill_ph   <= ~fill_ph;

      if (eav_evt) begin
        st      <= ST_BLANK;
        fill_ph <= 1'b0;
        if (st == ST_ACTIVE) act_len <= act_cnt;
      end else if (sav_evt) begin
        st      <= ST_ACTIVE;
        act_cnt <= '0;
        cur_f   <= in_data[6];
        cur_v   <= in_data[5];
      end else if (overrun) begin
        st <= ST_UNSYNC;
      end
    end
  end

endmodule

// File: rtl/vlp_line_meas.sv
module vlp_line_meas
  import vlp_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int LEN_625 = 1728,
  parameter int LEN_525 = 1716
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             eav_evt,
  input  logic             sav_after_blank,
  input  logic             overrun,
  output logic [CNT_W-1:0] meas_total,
  output logic [CNT_W-1:0] meas_blank,
  output logic [1:0]       std_mode
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] PRE_N   = CNT_W'(3);

  logic [CNT_W-1:0] tot_cnt, since_eav, prev_len, cur_len;
  logic             have_ref, prev_ok;
  logic [1:0]       cls;

  always_comb begin
    cur_len = tot_cnt + 1'b1;
    if (cur_len == CNT_W'(LEN_625))      cls = STD_625;
    else if (cur_len == CNT_W'(LEN_525)) cls = STD_525;
    else                                 cls = STD_OTHER;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tot_cnt    <= '0;
      since_eav  <= '0;
      prev_len   <= '0;
      have_ref   <= 1'b0;
      prev_ok    <= 1'b0;
      meas_total <= '0;
      meas_blank <= '0;
      std_mode   <= STD_NONE;
    end else begin
      if (in_valid) begin
        if (tot_cnt   != CNT_TOP) tot_cnt   <= tot_cnt + 1'b1;
        if (since_eav != CNT_TOP) since_eav <= since_eav + 1'b1;
      end
      if (eav_evt) begin
        tot_cnt   <= '0;
        since_eav <= '0;
        have_ref  <= 1'b1;
        if (have_ref) begin
          meas_total <= cur_len;
          prev_len   <= cur_len;
          prev_ok    <= 1'b1;
          std_mode   <= (prev_ok && (prev_len == cur_len)) ? cls : STD_NONE;
        end
      end
      if (sav_after_blank) meas_blank <= since_eav - PRE_N;
      if (overrun) begin
        have_ref <= 1'b0;
        prev_ok  <= 1'b0;
        std_mode <= STD_NONE;
      end
    end
  end

endmodule

// File: rtl/vline_parser.sv
module vline_parser #(
  parameter int ACT_LEN = 1440,
  parameter int LEN_625 = 1728,
  parameter int LEN_525 = 1716,
  parameter int CNT_W   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sol,
  output logic             out_eol,
  output logic             out_field,
  output logic             out_vblank,
  output logic             code_err,
  output logic             len_err,
  output logic             blank_err,
  output logic [CNT_W-1:0] meas_active,
  output logic [CNT_W-1:0] meas_total,
  output logic [CNT_W-1:0] meas_blank,
  output logic [1:0]       std_mode
);

  logic code_byte, hit_good, hit_bad;
  logic eav_evt, sav_after_blank, overrun;

  vlp_code_det u_det (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .code_byte (code_byte),
    .hit_good  (hit_good),
    .hit_bad   (hit_bad)
  );

  vlp_line_fsm #(.ACT_LEN(ACT_LEN), .CNT_W(CNT_W)) u_fsm (
    .clk             (clk),
    .rst             (rst),
    .in_valid        (in_valid),
    .in_data         (in_data),
    .code_byte       (code_byte),
    .hit_good        (hit_good),
    .hit_bad         (hit_bad),
    .o_valid         (out_valid),
    .o_data          (out_data),
    .o_sol           (out_sol),
    .o_eol           (out_eol),
    .o_field         (out_field),
    .o_vblank        (out_vblank),
    .code_err        (code_err),
    .len_err         (len_err),
    .blank_err       (blank_err),
    .act_len         (meas_active),
    .eav_evt         (eav_evt),
    .sav_after_blank (sav_after_blank),
    .overrun         (overrun)
  );

  vlp_line_meas #(.CNT_W(CNT_W), .LEN_625(LEN_625), .LEN_525(LEN_525)) u_meas (
    .clk             (clk),
    .rst             (rst),
    .in_valid        (in_valid),
    .eav_evt         (eav_evt),
    .sav_after_blank (sav_after_blank),
    .overrun         (overrun),
    .meas_total      (meas_total),
    .meas_blank      (meas_blank),
    .std_mode        (std_mode)
  );

endmodule

// File: rtl/vline_parser_chk.sv
module vline_parser_chk #(
  parameter int CNT_W   = 12,
  parameter int LEN_625 = 1728
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             out_sol,
  input logic             out_eol,
  input logic             code_err,
  input logic             len_err,
  input logic             blank_err,
  input logic [CNT_W-1:0] meas_total,
  input logic [1:0]       std_mode
);

  AST_SOL_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_sol |-> out_valid);                                            // R3
  AST_EOL_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_eol |-> out_valid);                                            // R3
  AST_NO_CODE_FORWARD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data != 8'hFF));                                // R2
  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);                                         // R9
  AST_CODE_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    code_err |=> code_err);                                            // R1
  AST_LEN_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    len_err |=> len_err);                                              // R6
  AST_BLANK_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    blank_err |=> blank_err);                                          // R5
  AST_STD625_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (std_mode == 2'b01) |-> (meas_total == CNT_W'(LEN_625)));          // R8

endmodule

bind vline_parser vline_parser_chk #(.CNT_W(CNT_W), .LEN_625(LEN_625)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_sol    (out_sol),
  .out_eol    (out_eol),
  .code_err   (code_err),
  .len_err    (len_err),
  .blank_err  (blank_err),
  .meas_total (meas_total),
  .std_mode   (std_mode)
);

// File: tb/vline_parser_bench.sv
module vline_parser_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ACT = 1440;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        out_valid, out_sol, out_eol, out_field, out_vblank;
  logic [7:0]  out_data;
  logic        code_err, len_err, blank_err;
  logic [11:0] meas_active, meas_total, meas_blank;
  logic [1:0]  std_mode;

  int n_chk = 0, n_fail = 0;
  int fwd, sol_bad, eol_bad, eol_seen, data_bad, stall_bad;
  logic last_f, last_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  vline_parser u_vline_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol),
    .out_eol(out_eol), .out_field(out_field), .out_vblank(out_vblank),
    .code_err(code_err), .len_err(len_err), .blank_err(blank_err),
    .meas_active(meas_active), .meas_total(meas_total),
    .meas_blank(meas_blank), .std_mode(std_mode)
  );

  function automatic logic [7:0] tword(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic [7:0] pix(input int i);
    return 8'(16 + (i % 200));
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic observe();
    if (out_valid) begin
      if (out_data != pix(fwd)) data_bad++;
      if (out_sol != (fwd == 0)) sol_bad++;
      if (out_eol != (fwd == ACT - 1)) eol_bad++;
      if (out_eol) eol_seen++;
      last_f = out_field;
      last_v = out_vblank;
      fwd++;
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    observe();
  endtask

  task automatic idle_byte();
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'hFF;
    @(posedge clk);
    #1;
    if (out_valid) stall_bad++;
  endtask

  task automatic put_code(input logic [7:0] w);
    put_byte(8'hFF); put_byte(8'h00); put_byte(8'h00); put_byte(w);
  endtask

  task automatic send_line(input logic [7:0] eav_w, input logic [7:0] sav_w,
                           input int nblank, input int nact, input int bad_idx,
                           input bit gaps);
    fwd = 0; sol_bad = 0; eol_bad = 0; eol_seen = 0; data_bad = 0;
    put_code(eav_w);
    for (int i = 0; i < nblank; i++) begin
      if (i == bad_idx) put_byte(8'h81);
      else put_byte((i % 2 == 0) ? 8'h80 : 8'h10);
      if (gaps && (i % 9 == 4)) idle_byte();
    end
    put_code(sav_w);
    for (int i = 0; i < nact; i++) begin
      put_byte(pix(i));
      if (gaps && (i % 7 == 3)) idle_byte();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic line_ok_checks(input string tag);
    check(fwd == ACT, {tag, " R2 forwarded count"}, fwd, ACT);
    check(data_bad == 0, {tag, " R2 data mismatches"}, data_bad, 0);
    check(sol_bad == 0 && eol_bad == 0 && eol_seen == 1, {tag, " R3 sol/eol"},
          sol_bad + eol_bad, 0);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check(!out_valid && !out_sol && !out_eol && !code_err && !len_err && !blank_err,
          "R10 outputs after reset", 1, 0);
    check(std_mode == 2'b00 && meas_total == 0, "R10 std/measure after reset",
          int'(std_mode), 0);
  endtask

  task automatic t_pal();
    do_reset();
    for (int l = 0; l < 3; l++) begin
      send_line(tword(0,0,1), tword(0,0,0), 280, ACT, -1, 0);
      line_ok_checks("pal");
    end
    check(std_mode == 2'b01, "R8 625 lock", int'(std_mode), 1);
    check(meas_total == 1728, "R7 total 625", int'(meas_total), 1728);
    check(meas_blank == 280, "R7 blank 625", int'(meas_blank), 280);
    check(meas_active == ACT, "R7 active count", int'(meas_active), ACT);
    check(!blank_err && !code_err && !len_err, "R5 clean stream no flags",
          int'(blank_err) + int'(code_err) + int'(len_err), 0);
    check(last_f == 0 && last_v == 0, "R4 F0V0 tags", int'({last_f, last_v}), 0);
    send_line(tword(1,0,1), tword(1,0,0), 280, ACT, -1, 0);
    check(last_f == 1 && last_v == 0, "R4 field tag", int'({last_f, last_v}), 2);
    send_line(tword(0,1,1), tword(0,1,0), 280, ACT, -1, 0);
    check(last_f == 0 && last_v == 1, "R4 vblank tag", int'({last_f, last_v}), 1);
    line_ok_checks("pal_v");
  endtask

  task automatic t_ntsc();
    do_reset();
    stall_bad = 0;
    for (int l = 0; l < 3; l++) begin
      send_line(tword(0,0,1), tword(0,0,0), 268, ACT, -1, 1);
      line_ok_checks("ntsc R9");
    end
    check(stall_bad == 0, "R9 idle bytes ignored", stall_bad, 0);
    check(std_mode == 2'b10, "R8 525 lock", int'(std_mode), 2);
    check(meas_total == 1716, "R7 total 525 with gaps", int'(meas_total), 1716);
    check(meas_blank == 268, "R7 blank 525 with gaps", int'(meas_blank), 268);
  endtask

  task automatic t_odd();
    do_reset();
    for (int l = 0; l < 3; l++) send_line(tword(0,0,1), tword(0,0,0), 270, ACT, -1, 0);
    check(std_mode == 2'b11, "R8 other length", int'(std_mode), 3);
    check(meas_total == 1718, "R7 total other", int'(meas_total), 1718);
  endtask

  task automatic t_mismatch();
    do_reset();
    for (int l = 0; l < 3; l++) send_line(tword(0,0,1), tword(0,0,0), 280, ACT, -1, 0);
    send_line(tword(0,0,1), tword(0,0,0), 268, ACT, -1, 0);
    check(std_mode == 2'b01, "R8 still 625 before change seen", int'(std_mode), 1);
    send_line(tword(0,0,1), tword(0,0,0), 280, ACT, -1, 0);
    check(std_mode == 2'b00, "R8 unlock on differing lengths", int'(std_mode), 0);
    check(meas_total == 1716, "R7 total of short line", int'(meas_total), 1716);
  endtask

  task automatic t_bad_code();
    do_reset();
    send_line(tword(0,0,1), tword(0,0,0), 280, ACT, -1, 0);
    check(code_err == 0, "R1 no code error on valid words", int'(code_err), 0);
    send_line(tword(0,0,1), tword(0,0,0) ^ 8'h01, 280, ACT, -1, 0);
    check(fwd == 0, "R1 bad start code ignored", fwd, 0);
    check(code_err == 1, "R1 code error set", int'(code_err), 1);
  endtask

  task automatic t_blank();
    do_reset();
    send_line(tword(0,0,1), tword(0,0,0), 280, ACT, 5, 0);
    check(blank_err == 1, "R5 broken fill flagged", int'(blank_err), 1);
    check(fwd == ACT, "R5 forwarding unaffected", fwd, ACT);
  endtask

  task automatic t_short();
    do_reset();
    send_line(tword(0,0,1), tword(0,0,0), 280, 100, -1, 0);
    check(len_err == 0, "R6 no error before end code", int'(len_err), 0);
    send_line(tword(0,0,1), tword(0,0,0), 280, ACT, -1, 0);
    check(len_err == 1, "R6 short line flagged", int'(len_err), 1);
  endtask

  task automatic t_over();
    do_reset();
    for (int l = 0; l < 3; l++) send_line(tword(0,0,1), tword(0,0,0), 280, ACT, -1, 0);
    send_line(tword(0,0,1), tword(0,0,0), 280, ACT + 10, -1, 0);
    check(fwd == ACT, "R6 overrun bytes dropped", fwd, ACT);
    check(len_err == 1, "R6 overrun flagged", int'(len_err), 1);
    check(std_mode == 2'b00, "R8 overrun clears lock", int'(std_mode), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_pal();
    t_ntsc();
    t_odd();
    t_mismatch();
    t_bad_code();
    t_blank();
    t_short();
    t_over();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule